// File: doc/BRIEF.md
# PHY Register Handshake Sequencer

This block turns a single register request (read or write, a 16-bit register address and, for writes, 16-bit data) into the strobe-by-strobe exchange that a PHY control port expects. It owns a 20-bit control word and watches a status word. The control word is a 16-bit value field plus four one-hot strobe bits. The status word carries an acknowledge flag and the read value.

Every access starts by presenting the address and capturing it. A write then presents and captures the data and fires the write strobe. A read fires the read strobe and takes the returned value. Each strobe is a full four-phase exchange: the strobe is raised, the acknowledge must go high, the strobe is dropped, and the acknowledge must go low. The acknowledge is polled at a fixed spacing with a bounded number of attempts. If a wait runs out of attempts, the access is abandoned and reported as an error. The acknowledge passes through a synchroniser, so the port may run from another clock.

Top module: `phy_hs_seq`

## Requirements
- R1: After reset the control word is all zeros, `req_ready` is 1 and `done` is 0. Whenever the sequencer is idle, the control word is zero.
- R2: A request is taken only while `req_ready` is 1, which holds only when idle. A `req_valid` pulse during an access has no effect on that access's control-word sequence or results.
- R3: Every access begins with the address phase. The control word first holds the address alone in bits 15:0. Bit 16 (address capture) is then added with the address unchanged. After the acknowledge goes high, the word returns to the address alone until the acknowledge goes low.
- R4: After the address phase, a write shows these words in order: the data alone; data plus bit 17 (data capture); the data alone; bit 18 (write) alone; the data alone; then zero on completion. Each strobe word stays until the acknowledge is high, and the word after it stays until the acknowledge is low.
- R5: After the address phase, a read shows bit 19 (read) alone until the acknowledge is high. It then latches status bits 15:0 as the result and sets the control word to zero while it waits for the acknowledge to go low.
- R6: At most one of the strobe bits 19:16 is set at any time, and every strobe is held for at least POLL_GAP cycles.
- R7: The acknowledge (status bit 16) is sampled once every POLL_GAP cycles, for at most MAX_POLLS samples per wait. A response that arrives inside that window lets the access continue. With defaults 4 and 10, a strobe that is never acknowledged is held for exactly 40 cycles.
- R8: On a timeout the access stops at once: `done` pulses with `err`=1, `rdata` is 0, the control word returns to zero and the sequencer goes idle, ready for a new request.
- R9: `done` is a one-cycle pulse at the end of each access, with `err`=0 on success. `rdata` carries the read value, or 0 for writes. Status bits above 15 never reach `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rdata | output | 16 | Read result, valid with done |
| ctrl_word | output | 20 | Control word to the PHY port |
| stat_word | input | STAT_W (32) | Status word from the PHY port |

## Verification
A bench-side PHY model captures the address and data and keeps a small register file. Each access is compared against the full expected sequence of control words and the expected result. Writes followed by read-back of the same and of untouched registers separate correct address and data capture from swapped or stale fields. Junk in the upper status bits exposes any leak into `rdata`. Four responder behaviours are used, and each tells apart a different rule of the poll window and abort path: prompt, late but inside the window, silent or too late, and acknowledge stuck high. A request pulsed during a busy access shows whether it is ignored.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

    localparam int FIELD_W  = 16;
    localparam int STRB_W   = 4;
    localparam int CTRL_W   = FIELD_W + STRB_W;
    localparam int BIT_CAPA = 16;
    localparam int BIT_CAPD = 17;
    localparam int BIT_WR   = 18;
    localparam int BIT_RD   = 19;
    localparam int STAT_ACK = 16;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR_SET, ST_ADDR_STB, ST_ADDR_REL,
        ST_DAT_SET, ST_DAT_STB, ST_DAT_REL, ST_WR_STB, ST_WR_REL,
        ST_RD_STB, ST_RD_REL, ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic               write;
        logic [FIELD_W-1:0] addr;
        logic [FIELD_W-1:0] data;
    } acc_req_t;

    function automatic logic [CTRL_W-1:0] strobe_only(input int pos);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[pos] = 1'b1;
        return w;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_for(input seq_state_t s, input acc_req_t r);
        logic [CTRL_W-1:0] w;
        case (s)
            ST_ADDR_SET, ST_ADDR_REL:         w = {{STRB_W{1'b0}}, r.addr};
            ST_ADDR_STB:                      w = {{STRB_W{1'b0}}, r.addr} | strobe_only(BIT_CAPA);
            ST_DAT_SET, ST_DAT_REL, ST_WR_REL: w = {{STRB_W{1'b0}}, r.data};
            ST_DAT_STB:                       w = {{STRB_W{1'b0}}, r.data} | strobe_only(BIT_CAPD);
            ST_WR_STB:                        w = strobe_only(BIT_WR);
            ST_RD_STB:                        w = strobe_only(BIT_RD);
            default:                          w = '0;
        endcase
        return w;
    endfunction

    function automatic logic is_wait(input seq_state_t s);
        return (s == ST_ADDR_STB) || (s == ST_ADDR_REL) || (s == ST_DAT_STB) ||
               (s == ST_DAT_REL)  || (s == ST_WR_STB)   || (s == ST_WR_REL)  ||
               (s == ST_RD_STB)   || (s == ST_RD_REL);
    endfunction

    function automatic logic want_high(input seq_state_t s);
        return (s == ST_ADDR_STB) || (s == ST_DAT_STB) || (s == ST_WR_STB) || (s == ST_RD_STB);
    endfunction

    function automatic seq_state_t after_wait(input seq_state_t s, input logic wr);
        seq_state_t n;
        case (s)
            ST_ADDR_STB: n = ST_ADDR_REL;
            ST_ADDR_REL: n = wr ? ST_DAT_SET : ST_RD_STB;
            ST_DAT_STB:  n = ST_DAT_REL;
            ST_DAT_REL:  n = ST_WR_STB;
            ST_WR_STB:   n = ST_WR_REL;
            ST_RD_STB:   n = ST_RD_REL;
            default:     n = ST_DONE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/phy_hs_sync.sv
module phy_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/phy_hs_poll.sv
module phy_hs_poll #(
    parameter int GAP   = 4,
    parameter int TRIES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic enable,
    input  logic level,
    input  logic want,
    output logic met,
    output logic expired
);
    localparam int GAP_W = $clog2(GAP + 1);
    localparam int TRY_W = $clog2(TRIES + 1);

    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] try_q;
    logic             sample;

    assign sample  = enable && (gap_q == GAP_W'(GAP - 1));
    assign met     = sample && (level == want);
    assign expired = sample && (level != want) && (try_q == TRY_W'(TRIES - 1));

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            gap_q <= '0;
            try_q <= '0;
        end else if (enable) begin
            if (sample) begin
                gap_q <= '0;
                try_q <= try_q + 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
    import phy_hs_pkg::*;
#(
    parameter int POLL_GAP    = 4,
    parameter int MAX_POLLS   = 10,
    parameter int SYNC_STAGES = 2,
    parameter int STAT_W      = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [FIELD_W-1:0]  req_addr,
    input  logic [FIELD_W-1:0]  req_wdata,
    output logic                done,
    output logic                err,
    output logic [FIELD_W-1:0]  rdata,
    output logic [CTRL_W-1:0]   ctrl_word,
    input  logic [STAT_W-1:0]   stat_word
);
    seq_state_t         state_q, state_n;
    acc_req_t           req_q, req_n;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               err_q, err_n;
    logic [FIELD_W-1:0] rdata_q, rdata_n;
    logic               ack_s, waiting, want, arm, met, expired;

    phy_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(stat_word[STAT_ACK]), .q(ack_s)
    );

    assign waiting = is_wait(state_q);
    assign want    = want_high(state_q);
    assign arm     = (state_n != state_q);

    phy_hs_poll #(.GAP(POLL_GAP), .TRIES(MAX_POLLS)) u_poll (
        .clk(clk), .rst(rst), .arm(arm), .enable(waiting),
        .level(ack_s), .want(want), .met(met), .expired(expired)
    );

    always_comb begin
        state_n = state_q;
        req_n   = req_q;
        err_n   = err_q;
        rdata_n = rdata_q;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_n = ST_ADDR_SET;
                    req_n   = '{write: req_write, addr: req_addr, data: req_wdata};
                    err_n   = 1'b0;
                    rdata_n = '0;
                end
            end
            ST_ADDR_SET: state_n = ST_ADDR_STB;
            ST_DAT_SET:  state_n = ST_DAT_STB;
            ST_DONE:     state_n = ST_IDLE;
            default: begin
                if (expired) begin
                    state_n = ST_DONE;
                    err_n   = 1'b1;
                    rdata_n = '0;
                end else if (met) begin
                    state_n = after_wait(state_q, req_q.write);
                    if (state_q == ST_RD_STB)
                        rdata_n = stat_word[FIELD_W-1:0];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            ctrl_q  <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_n;
            req_q   <= req_n;
            ctrl_q  <= ctrl_for(state_n, req_n);
            err_q   <= err_n;
            rdata_q <= rdata_n;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign err       = err_q;
    assign rdata     = rdata_q;
    assign ctrl_word = ctrl_q;
endmodule

// File: rtl/phy_hs_seq_chk.sv
module phy_hs_seq_chk #(
    parameter int POLL_GAP = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        done,
    input logic        err,
    input logic [15:0] rdata,
    input logic [19:0] ctrl_word
);
    int unsigned hold_q;

    always_ff @(posedge clk) begin
        if (rst)                        hold_q <= 0;
        else if (ctrl_word[19:16] != 0) hold_q <= hold_q + 1;
        else                            hold_q <= 0;
    end

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ctrl_word == 20'h0));

    a_r2_busy_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

    a_r3_capa_keeps_addr: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_word[16]) |-> $stable(ctrl_word[15:0]));

    a_r5_read_release_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_word[19]) |-> (ctrl_word == 20'h0));

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones(ctrl_word[19:16]) <= 1);

    a_r6_strobe_width: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_word[19:16] == 4'h0) && ($past(ctrl_word[19:16]) != 4'h0)) |-> (hold_q >= POLL_GAP));

    a_r8_err_clean: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> ((ctrl_word == 20'h0) && (rdata == 16'h0)));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind phy_hs_seq phy_hs_seq_chk #(.POLL_GAP(POLL_GAP)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
    .err(err), .rdata(rdata), .ctrl_word(ctrl_word)
);

// File: tb/sim_phy_hs_seq.sv
module sim_phy_hs_seq;
    localparam int CLK_PERIOD = 10;
    localparam int GAP   = 4;
    localparam int TRIES = 10;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [15:0] req_addr = 0, req_wdata = 0;
    logic        req_ready, done, err;
    logic [15:0] rdata;
    logic [19:0] ctrl_word;
    logic [31:0] stat_word;

    phy_hs_seq #(.POLL_GAP(GAP), .MAX_POLLS(TRIES)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .err(err), .rdata(rdata), .ctrl_word(ctrl_word), .stat_word(stat_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // PHY responder model: 0 normal, 1 silent, 2 ack stuck high
    int          mode = 0;
    int          lat  = 2;
    int          lcnt = 0;
    logic        ack_r = 0;
    logic [15:0] cap_a = 0, cap_d = 0, rd_val = 0;
    logic [15:0] phy_mem [16];
    logic        ack_out;

    assign ack_out   = (mode == 2) ? 1'b1 : (mode == 1) ? 1'b0 : ack_r;
    assign stat_word = {15'h6B3D, ack_out, rd_val};

    always @(posedge clk) begin
        if (mode == 0) begin
            if ((|ctrl_word[19:16]) != ack_r) begin
                if (lcnt + 1 >= lat) begin
                    ack_r <= |ctrl_word[19:16];
                    lcnt  <= 0;
                    if (!ack_r) begin
                        if (ctrl_word[16]) cap_a <= ctrl_word[15:0];
                        if (ctrl_word[17]) cap_d <= ctrl_word[15:0];
                        if (ctrl_word[18]) phy_mem[cap_a[3:0]] <= cap_d;
                        if (ctrl_word[19]) rd_val <= phy_mem[cap_a[3:0]];
                    end
                end else lcnt <= lcnt + 1;
            end else lcnt <= 0;
        end
    end

    // scoreboard
    bit          exp_err_q [$];
    logic [15:0] exp_rd_q  [$];
    int          exp_len_q [$];
    logic [19:0] exp_seq_q [$];
    string       exp_tag_q [$];
    logic [19:0] seen [$];
    logic [19:0] last_ctrl = 0;
    logic [15:0] model_mem [16];
    int          capa_cycles = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ctrl_word[16]) capa_cycles++;
            if (ctrl_word != last_ctrl) begin
                seen.push_back(ctrl_word);
                last_ctrl = ctrl_word;
            end
            if (done) begin
                if (exp_err_q.size() == 0) begin
                    chk(0, "R9 unexpected done", 32'(done), 32'h0);
                end else begin
                    automatic bit          e_err = exp_err_q.pop_front();
                    automatic logic [15:0] e_rd  = exp_rd_q.pop_front();
                    automatic int          e_len = exp_len_q.pop_front();
                    automatic string       tag   = exp_tag_q.pop_front();
                    automatic bit          same  = (seen.size() == e_len);
                    automatic logic [19:0] a_w = 0, e_w = 0;
                    for (int i = 0; i < e_len; i++) begin
                        automatic logic [19:0] w = exp_seq_q.pop_front();
                        if (same && i < seen.size() && seen[i] != w) begin
                            same = 0; a_w = seen[i]; e_w = w;
                        end
                    end
                    if (seen.size() != e_len) begin a_w = 20'(seen.size()); e_w = 20'(e_len); end
                    chk(same, {tag, " control word sequence"}, 32'(a_w), 32'(e_w));
                    chk(err == e_err, {tag, " err"}, 32'(err), 32'(e_err));
                    chk(rdata == e_rd, {tag, " rdata"}, 32'(rdata), 32'(e_rd));
                end
                seen.delete();
            end
        end
    end

    task automatic push_w(ref logic [19:0] q[$], input logic [19:0] w, ref logic [19:0] prev);
        if (w != prev) begin q.push_back(w); prev = w; end
    endtask

    // kind: 0 ok, 1 no ack at address strobe, 2 ack stuck high
    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input int kind, input string tag, input bit poke);
        logic [19:0] s [$];
        logic [19:0] p = 0;
        push_w(s, {4'h0, a}, p);
        push_w(s, {4'h1, a}, p);
        if (kind == 1) begin
            push_w(s, 20'h0, p);
        end else begin
            push_w(s, {4'h0, a}, p);
            if (kind == 2) push_w(s, 20'h0, p);
            else if (wr) begin
                push_w(s, {4'h0, d}, p); push_w(s, {4'h2, d}, p); push_w(s, {4'h0, d}, p);
                push_w(s, 20'h40000, p); push_w(s, {4'h0, d}, p); push_w(s, 20'h0, p);
            end else begin
                push_w(s, 20'h80000, p); push_w(s, 20'h0, p);
            end
        end
        exp_tag_q.push_back(tag);
        exp_err_q.push_back(kind != 0);
        exp_rd_q.push_back((kind == 0 && !wr) ? model_mem[a[3:0]] : 16'h0);
        exp_len_q.push_back(s.size());
        foreach (s[i]) exp_seq_q.push_back(s[i]);
        if (kind == 0 && wr) model_mem[a[3:0]] = d;

        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            repeat (5) @(negedge clk);
            chk(!req_ready, "R2 ready low while busy", 32'(req_ready), 32'h0);
            req_valid = 1; req_write = ~wr; req_addr = 16'h00EE; req_wdata = 16'h5555;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
        while (exp_err_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            phy_mem[i]   = 16'h4000 + 16'(i) * 16'h0101;
            model_mem[i] = 16'h4000 + 16'(i) * 16'h0101;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ctrl_word == 0, "R1 reset ctrl", 32'(ctrl_word), 32'h0);
        chk(req_ready == 1, "R1 reset ready", 32'(req_ready), 32'h1);
        chk(done == 0, "R1 reset done", 32'(done), 32'h0);

        access(1, 16'h0013, 16'hBEEF, 0, "R4 write", 0);
        access(0, 16'h0013, 16'h0000, 0, "R5 read back R2 poke", 1);
        access(1, 16'h0025, 16'h1234, 0, "R3 write", 0);
        access(0, 16'h0025, 16'h0000, 0, "R9 read", 0);
        access(0, 16'h0007, 16'h0000, 0, "R5 read untouched", 0);

        mode = 1; capa_cycles = 0;
        access(0, 16'h0031, 16'h0000, 1, "R8 silent read", 0);
        chk(capa_cycles == GAP * TRIES, "R7 silent strobe width", 32'(capa_cycles), 32'(GAP * TRIES));
        mode = 2;
        access(1, 16'h0042, 16'h7777, 2, "R8 stuck ack write", 0);
        mode = 0; lat = 30;
        repeat (40) @(negedge clk);
        access(1, 16'h0019, 16'h0F0F, 0, "R7 late write", 0);
        access(0, 16'h0019, 16'h0000, 0, "R7 late read", 0);
        lat = 60; capa_cycles = 0;
        access(0, 16'h0013, 16'h0000, 1, "R7 too late read", 0);
        chk(capa_cycles == GAP * TRIES, "R7 too late strobe width", 32'(capa_cycles), 32'(GAP * TRIES));
        lat = 2;
        repeat (80) @(negedge clk);
        access(0, 16'h0013, 16'h0000, 0, "R8 recover read", 0);
        chk(req_ready == 1 && ctrl_word == 0, "R1 idle at end", {ctrl_word, 11'h0, req_ready}, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule